// File: doc/BRIEF.md
# Consumer-Control Key Status Reporter

This block watches three push-button lines for mute, volume up and volume down. It turns their settled state into consumer-control reports for an interrupt-IN endpoint. Each raw line is first brought into the clock domain and then filtered against contact bounce, with the filter sampling on the 1 ms frame tick. A frame-tick counter marks the reporting boundary, which by default falls every 32 ms. At a boundary a fresh report is captured. It is held on the output until the endpoint logic acknowledges it.

A report has three 16-bit usage slots. The pressed keys fill these slots in a fixed priority order, and any slot left over reads zero. While at least one key stays down, a report goes out at every boundary. After the last key is let go, one all-zero report tells the host that everything was released, and reporting then stops. The keys only produce reports; they have no path into any audio data.

Top module: `hidkey_reporter`

## Requirements
- R1: After reset, `rpt_valid` is 0 and `rpt_data` is all zero.
- R2: Key bit 0 is mute with usage code 0xE209, bit 1 is volume up with 0xE909, and bit 2 is volume down with 0xEA09; a high level means pressed.
- R3: Pressed keys fill the slots in the order mute, volume up, volume down. Slot 0 is `rpt_data[15:0]`, slot 1 is `[31:16]` and slot 2 is `[47:32]`, and every unused slot is 0x0000.
- R4: A key level takes effect only after STABLE_TICKS consecutive frame-tick samples agree on it. A pulse that spans fewer ticks produces no report.
- R5: A report is captured only at an interval boundary, and boundaries are INTERVAL_TICKS frame ticks apart. While a key stays pressed and each report is acknowledged promptly, consecutive reports are INTERVAL_TICKS ticks apart.
- R6: Once `rpt_valid` is high, it stays high and `rpt_data` stays unchanged until `ep_ack` is sampled high. A boundary that occurs in the meantime changes nothing.
- R7: After the last key is released, exactly one all-zero report is sent, and no further report follows while all keys stay released.
- R8: While no key has been pressed since reset, no report is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_tick | input | 1 | One-cycle pulse once per 1 ms frame |
| key_raw | input | 3 | Raw key lines: bit 0 mute, bit 1 volume up, bit 2 volume down |
| ep_ack | input | 1 | Endpoint has taken the pending report |
| rpt_valid | output | 1 | A report is pending |
| rpt_data | output | 48 | Three 16-bit usage slots, slot 0 in the low bits |

## Verification
The bench builds the block with STABLE_TICKS = 3 and INTERVAL_TICKS = 5, and issues a frame tick every fourth clock. With these values a whole debounce window and several reporting intervals fit into a few dozen ticks. That makes it practical to sweep all eight key combinations through press and release, and to check the slot packing against priority that the bench computes itself. The short windows also bring within reach a glitch one tick shorter than the filter window, interval spacing measured in ticks, and a report held across two boundaries while the keys change underneath it.

// File: rtl/hidkey_pkg.sv
package hidkey_pkg;

    localparam int NUM_KEYS = 3;
    localparam int CODE_W   = 16;
    localparam int RPT_W    = NUM_KEYS * CODE_W;

    typedef logic [NUM_KEYS-1:0] key_vec_t;
    typedef logic [CODE_W-1:0]   usage_t;
    typedef logic [RPT_W-1:0]    report_t;

    typedef enum logic [1:0] {
        KEY_MUTE  = 2'd0,
        KEY_VOLUP = 2'd1,
        KEY_VOLDN = 2'd2
    } key_id_e;

    typedef struct packed {
        logic    valid;
        report_t data;
    } rpt_hold_t;

    function automatic usage_t usage_code(input int idx);
        usage_t code;
        case (idx)
            int'(KEY_MUTE):  code = 16'hE209;
            int'(KEY_VOLUP): code = 16'hE909;
            int'(KEY_VOLDN): code = 16'hEA09;
            default:         code = '0;
        endcase
        return code;
    endfunction

    // Slot order follows key index, which is also the priority order.
    function automatic report_t pack_report(input key_vec_t keys);
        report_t r;
        int      slot;
        r    = '0;
        slot = 0;
        for (int i = 0; i < NUM_KEYS; i++) begin
            if (keys[i]) begin
                r[slot*CODE_W +: CODE_W] = usage_code(i);
                slot++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/hidkey_debounce.sv
module hidkey_debounce #(
    parameter int STABLE_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic raw_i,
    output logic level_o
);
    localparam int CNT_W = (STABLE_TICKS < 2) ? 1 : $clog2(STABLE_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_TICKS - 1);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] agree_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '0;
            agree_q <= '0;
            level_o <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (tick_i) begin
                if (sync_q[1] == level_o) begin
                    agree_q <= '0;
                end else if (agree_q == LAST) begin
                    level_o <= sync_q[1];
                    agree_q <= '0;
                end else begin
                    agree_q <= agree_q + 1'b1;
                end
            end
        end
    end

    // R4: the filtered level moves only on a frame-tick sample
    assert_change_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        (level_o != $past(level_o)) |-> $past(tick_i));

    // R4: the agreement count never runs past the window
    assert_window_bound_R4: assert property (@(posedge clk) disable iff (rst)
        agree_q <= LAST);

endmodule

// File: rtl/hidkey_interval.sv
module hidkey_interval #(
    parameter int INTERVAL_TICKS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic boundary_o
);
    localparam int CNT_W = (INTERVAL_TICKS < 2) ? 1 : $clog2(INTERVAL_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL_TICKS - 1);

    logic [CNT_W-1:0] tick_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt_q <= '0;
            boundary_o <= 1'b0;
        end else begin
            boundary_o <= 1'b0;
            if (tick_i) begin
                if (tick_cnt_q == LAST) begin
                    tick_cnt_q <= '0;
                    boundary_o <= 1'b1;
                end else begin
                    tick_cnt_q <= tick_cnt_q + 1'b1;
                end
            end
        end
    end

    // R5: a boundary is always caused by a frame tick
    assert_boundary_after_tick_R5: assert property (@(posedge clk) disable iff (rst)
        boundary_o |-> $past(tick_i));

    // R5: boundaries are single-cycle pulses
    assert_boundary_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        boundary_o |=> !boundary_o);

endmodule

// File: rtl/hidkey_report_hold.sv
module hidkey_report_hold
    import hidkey_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  key_vec_t keys_i,
    input  logic     boundary_i,
    input  logic     ack_i,
    output logic     valid_o,
    output report_t  data_o
);
    rpt_hold_t hold_q;
    logic      release_pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q         <= '0;
            release_pend_q <= 1'b0;
        end else if (hold_q.valid) begin
            if (ack_i) begin
                hold_q.valid <= 1'b0;
            end
        end else if (boundary_i) begin
            if (keys_i != '0) begin
                hold_q.valid   <= 1'b1;
                hold_q.data    <= pack_report(keys_i);
                release_pend_q <= 1'b1;
            end else if (release_pend_q) begin
                hold_q.valid   <= 1'b1;
                hold_q.data    <= '0;
                release_pend_q <= 1'b0;
            end
        end
    end

    assign valid_o = hold_q.valid;
    assign data_o  = hold_q.data;

    // R6: a pending report is frozen until acknowledged
    assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !ack_i) |=> (valid_o && $stable(data_o)));

    // R5: a new report appears only right after a boundary
    assert_rise_on_boundary_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> $past(boundary_i));

    // R3: slots fill from the bottom, so an empty slot 0 means an empty report
    assert_slots_packed_R3: assert property (@(posedge clk) disable iff (rst)
        (valid_o && data_o[CODE_W-1:0] == '0) |-> (data_o == '0));

    // R7: two zero reports never come back to back
    assert_single_release_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(valid_o) && data_o == '0) |-> !(release_pend_q));

endmodule

// File: rtl/hidkey_reporter.sv
module hidkey_reporter
    import hidkey_pkg::*;
#(
    parameter int STABLE_TICKS   = 4,
    parameter int INTERVAL_TICKS = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       frame_tick,
    input  logic [NUM_KEYS-1:0]        key_raw,
    input  logic                       ep_ack,
    output logic                       rpt_valid,
    output logic [NUM_KEYS*CODE_W-1:0] rpt_data
);
    key_vec_t key_stable;
    logic     boundary;
    report_t  data_int;

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        hidkey_debounce #(
            .STABLE_TICKS(STABLE_TICKS)
        ) u_deb (
            .clk    (clk),
            .rst    (rst),
            .tick_i (frame_tick),
            .raw_i  (key_raw[k]),
            .level_o(key_stable[k])
        );
    end

    hidkey_interval #(
        .INTERVAL_TICKS(INTERVAL_TICKS)
    ) u_interval (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (frame_tick),
        .boundary_o(boundary)
    );

    hidkey_report_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .keys_i    (key_stable),
        .boundary_i(boundary),
        .ack_i     (ep_ack),
        .valid_o   (rpt_valid),
        .data_o    (data_int)
    );

    assign rpt_data = data_int;

endmodule

// File: tb/hidkey_reporter_test.sv
`timescale 1ns/1ps
module hidkey_reporter_test;

    localparam int S   = 3;
    localparam int IV  = 5;
    localparam int TPC = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_tick = 1'b0;
    logic [2:0]  key_raw = '0;
    logic        ep_ack = 1'b0;
    logic        rpt_valid;
    logic [47:0] rpt_data;

    int n_checks = 0;
    int n_fail   = 0;
    int tick_count = 0;
    bit auto_ack = 1'b1;
    bit done = 1'b0;

    logic [47:0] log_data [0:63];
    int          log_tick [0:63];
    int          n_log = 0;

    hidkey_reporter #(.STABLE_TICKS(S), .INTERVAL_TICKS(IV)) uut (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .key_raw(key_raw),
        .ep_ack(ep_ack), .rpt_valid(rpt_valid), .rpt_data(rpt_data)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            repeat (TPC - 1) @(negedge clk);
            frame_tick = 1'b1;
            tick_count++;
            @(negedge clk);
            frame_tick = 1'b0;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (auto_ack && rpt_valid && !ep_ack) begin
                if (n_log < 64) begin
                    log_data[n_log] = rpt_data;
                    log_tick[n_log] = tick_count;
                end
                n_log++;
                ep_ack = 1'b1;
            end else begin
                ep_ack = 1'b0;
            end
        end
    end

    function automatic logic [47:0] expect_rpt(input logic [2:0] k);
        logic [15:0] codes [0:2];
        logic [47:0] r;
        int pos;
        codes[0] = 16'hE209;
        codes[1] = 16'hE909;
        codes[2] = 16'hEA09;
        r   = '0;
        pos = 0;
        for (int i = 0; i < 3; i++) begin
            if (k[i]) begin
                r   = r | ({32'd0, codes[i]} << (16 * pos));
                pos = pos + 1;
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * TPC) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [47:0] held;
        int bad;
        int zeros;
        repeat (5) @(negedge clk);
        check("R1 valid after reset", {63'd0, rpt_valid}, 64'd0);
        check("R1 data after reset", {16'd0, rpt_data}, 64'd0);
        rst = 1'b0;

        // R8: idle after reset produces nothing
        wait_ticks(3 * IV);
        check("R8 no report while idle", n_log, 0);

        // R2 R3 R5 R7: sweep every key combination
        for (int c = 1; c < 8; c++) begin
            n_log = 0;
            key_raw = c[2:0];
            wait_ticks(S + 2 * IV + 3);
            check("R5 at least two reports while held", {63'd0, n_log >= 2}, 64'd1);
            bad = 0;
            for (int i = 0; i < n_log && i < 64; i++)
                if (log_data[i] !== expect_rpt(c[2:0])) bad++;
            check("R3 slot packing by priority", n_log > 0 ? {16'd0, log_data[0]} : 64'hDEAD,
                  {16'd0, expect_rpt(c[2:0])});
            check("R2 every held report carries codes", bad, 0);
            if (n_log >= 2 && n_log <= 64)
                check("R5 report spacing in ticks", log_tick[n_log-1] - log_tick[n_log-2], IV);
            n_log = 0;
            key_raw = '0;
            wait_ticks(S + 2 * IV + 3);
            zeros = 0;
            bad = 0;
            for (int i = 0; i < n_log && i < 64; i++) begin
                if (log_data[i] == '0) zeros++;
                else if (log_data[i] !== expect_rpt(c[2:0])) bad++;
            end
            check("R7 exactly one release report", zeros, 1);
            check("R7 release report is last",
                  (n_log > 0 && n_log <= 64) ? {16'd0, log_data[n_log-1]} : 64'hDEAD, 64'd0);
            check("R7 no stray report content", bad, 0);
        end

        // R7: nothing more once release was reported
        n_log = 0;
        wait_ticks(2 * IV);
        check("R7 silence after release", n_log, 0);

        // R4: pulse spanning S-1 ticks is filtered out
        n_log = 0;
        key_raw = 3'b001;
        repeat ((S - 1) * TPC) @(negedge clk);
        key_raw = '0;
        wait_ticks(3 * IV);
        check("R4 short pulse ignored", n_log, 0);
        check("R4 short pulse leaves valid low", {63'd0, rpt_valid}, 64'd0);

        // R6: report held across boundaries until acknowledged
        auto_ack = 1'b0;
        n_log = 0;
        key_raw = 3'b101;
        wait_ticks(S + IV + 3);
        check("R6 report pending", {63'd0, rpt_valid}, 64'd1);
        check("R6 pending content", {16'd0, rpt_data}, {16'd0, expect_rpt(3'b101)});
        held = rpt_data;
        key_raw = 3'b010;
        wait_ticks(2 * IV + S);
        check("R6 still pending after boundaries", {63'd0, rpt_valid}, 64'd1);
        check("R6 content frozen", {16'd0, rpt_data}, {16'd0, held});
        auto_ack = 1'b1;
        wait_ticks(1);
        check("R6 acknowledged report is the held one",
              n_log > 0 ? {16'd0, log_data[0]} : 64'hDEAD, {16'd0, held});
        n_log = 0;
        wait_ticks(2 * IV + 1);
        check("R6 new keys reported after ack",
              n_log > 0 ? {16'd0, log_data[0]} : 64'hDEAD, {16'd0, expect_rpt(3'b010)});
        key_raw = '0;
        wait_ticks(S + 2 * IV + 3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule